// File: doc/BRIEF.md
# Secure doorbell mailbox

This block is a register-mapped mailbox through which an application processor and a system control processor signal each other with doorbell bits. It holds two one-way channels. The request channel carries commands toward the controller, and the response channel carries replies back toward the application processor. Each channel has a 32-bit status word. Bits 30:0 are 31 independent doorbell slots. Bit 31 is a sticky flag that records a non-secure access attempt on that channel.

Software rings a slot by writing a one to the slot's bit in the channel's set register. The receiver acknowledges by writing a one to the same bit in the clear register. The sender polls the request status to learn that a slot has been consumed. A nonzero response status means that a reply is waiting. Each channel drives a level interrupt toward its receiver while any of its slots is pending. Accesses are single-cycle register reads and writes on a 32-bit port with a non-secure attribute line.

Top module: `doorbell_mbox`

## Requirements
- R1: The response channel's status, set and clear registers sit at byte addresses 0x200, 0x208 and 0x210. The request channel's sit at 0x300, 0x308 and 0x310. A secure read of a status address returns that channel's status word.
- R2: A secure write to a set register ORs bits 30:0 of the write data into the channel status. Bits written as zero leave the status unchanged.
- R3: A secure write to a clear register clears every status bit written as one, bit 31 included, and leaves the other bits unchanged.
- R4: After reset both status words read zero and both interrupts are low.
- R5: Status registers are read-only. A secure write to a status address has no effect, and bit 31 of a secure set write is ignored.
- R6: A channel's interrupt is high exactly while any of its status bits 30:0 is one. Bit 31 alone does not raise it.
- R7: A non-secure read or write of any of a channel's three registers leaves bits 30:0 unchanged and sets that channel's bit 31. A non-secure read returns zero.
- R8: Bit 31 stays set until a secure clear write with bit 31 at one.
- R9: Reads of set and clear registers return zero. Every other address reads zero, and writes to those addresses change nothing.
- R10: An access to one channel never changes the other channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Slave selected |
| bus_en_i | input | 1 | Access phase; the access takes effect when sel and en are both high |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_nonsec_i | input | 1 | 1 = non-secure access |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid during the access cycle |
| req_irq_o | output | 1 | Request channel interrupt toward the controller |
| rsp_irq_o | output | 1 | Response channel interrupt toward the application processor |

## Verification
The bench rings and clears every slot of both channels, one at a time and in patterns. A design that decodes the wrong channel or drops the mask on bit 31 would then show a stray bit in the other status word, or an interrupt raised by the flag alone. It writes all-ones to every undefined word address and reads each one back. A loose decoder would then show corrupted status or nonzero read data. It mixes non-secure reads and writes with secure traffic to catch a design that lets such an access touch slots, leak status, or lose the sticky flag before an explicit secure clear.

// File: rtl/doorbell_mbox_pkg.sv
package doorbell_mbox_pkg;
  localparam int NUM_CH   = 2;   // 0: response, 1: request
  localparam int OFF_STAT = 'h00;
  localparam int OFF_SET  = 'h08;
  localparam int OFF_CLR  = 'h10;

  function automatic int ch_base(int ch);
    return 'h200 + ch * 'h100;
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import doorbell_mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] stat_hit_o,
  output logic [NUM_CH-1:0] set_hit_o,
  output logic [NUM_CH-1:0] clr_hit_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ch_base(c) + OFF_STAT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(ch_base(c) + OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ch_base(c) + OFF_CLR);
    assign stat_hit_o[c] = access_i && (addr_i == A_STAT);
    assign set_hit_o[c]  = access_i && (addr_i == A_SET);
    assign clr_hit_o[c]  = access_i && (addr_i == A_CLR);
  end

  // R10
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stat_hit_o, set_hit_o, clr_hit_o}));
  // R9
  no_hit_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access_i |-> ({stat_hit_o, set_hit_o, clr_hit_o} == '0));
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_hit_i,
  input  logic              set_hit_i,
  input  logic              clr_hit_i,
  input  logic              write_i,
  input  logic              nonsec_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int FLAG = DATA_W - 1;
  localparam logic [DATA_W-1:0] SLOT_MASK = {1'b0, {FLAG{1'b1}}};

  logic [DATA_W-1:0] status_q, status_d, set_vec, clr_vec;
  logic any_hit, sec_set, sec_clr;

  assign any_hit = stat_hit_i || set_hit_i || clr_hit_i;
  assign sec_set = set_hit_i && write_i && !nonsec_i;
  assign sec_clr = clr_hit_i && write_i && !nonsec_i;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (any_hit && nonsec_i) set_vec[FLAG] = 1'b1;
    if (sec_set) set_vec = set_vec | (wdata_i & SLOT_MASK);
    if (sec_clr) clr_vec = wdata_i;
    // clear first, then set
    status_d = (status_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign rdata_o = (stat_hit_i && !write_i && !nonsec_i) ? status_q : '0;
  assign irq_o   = |status_q[FLAG-1:0];

  // R2
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_set |=> (((($past(wdata_i)) & SLOT_MASK) & ~status_q) == '0));
  // R3
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_clr |=> ((status_q & $past(wdata_i)) == '0));
  // R7
  ns_slots_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_hit && nonsec_i) |=> (status_q[FLAG] &&
      (status_q[FLAG-1:0] == $past(status_q[FLAG-1:0]))));
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[FLAG] && !(sec_clr && wdata_i[FLAG])) |=> status_q[FLAG]);
  // R6
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_set && |wdata_i[FLAG-1:0]) |=> irq_o);
  // R5
  stat_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_hit_i && write_i && !nonsec_i) |=> $stable(status_q));
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import doorbell_mbox_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_en_i,
  input  logic              bus_write_i,
  input  logic              bus_nonsec_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              req_irq_o,
  output logic              rsp_irq_o
);
  localparam int CH_RSP = 0;
  localparam int CH_REQ = 1;

  logic                access;
  logic [NUM_CH-1:0]   stat_hit, set_hit, clr_hit, irq;
  logic [DATA_W-1:0]   ch_rdata [NUM_CH];

  assign access = bus_sel_i && bus_en_i;

  mbox_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .access_i   (access),
    .addr_i     (bus_addr_i),
    .stat_hit_o (stat_hit),
    .set_hit_o  (set_hit),
    .clr_hit_o  (clr_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    mbox_channel #(.DATA_W(DATA_W)) u_channel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stat_hit_i (stat_hit[c]),
      .set_hit_i  (set_hit[c]),
      .clr_hit_i  (clr_hit[c]),
      .write_i    (bus_write_i),
      .nonsec_i   (bus_nonsec_i),
      .wdata_i    (bus_wdata_i),
      .rdata_o    (ch_rdata[c]),
      .irq_o      (irq[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) bus_rdata_o = bus_rdata_o | ch_rdata[c];
  end

  assign req_irq_o = irq[CH_REQ];
  assign rsp_irq_o = irq[CH_RSP];

  // R9
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!access || bus_write_i || bus_nonsec_i) |-> (bus_rdata_o == '0));
  // R4
  irq_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!req_irq_o && !rsp_irq_o));
endmodule

// File: tb/doorbell_mbox_bench.sv
module doorbell_mbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [31:0] SLOTS = 32'h7FFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, en = 0, wr = 0, ns = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic req_irq, rsp_irq;

  int checks = 0, fails = 0;
  logic [31:0] exp_st [2];   // 0: response, 1: request

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_mbox u_doorbell_mbox (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_en_i(en),
    .bus_write_i(wr), .bus_nonsec_i(ns), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .req_irq_o(req_irq), .rsp_irq_o(rsp_irq)
  );

  function automatic int base(int ch);
    return 'h200 + ch * 'h100;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model update, done alongside each write/read
  function automatic void model(int a, logic w, logic n, logic [31:0] d);
    for (int c = 0; c < 2; c++) begin
      if (a == base(c) || a == base(c) + 8 || a == base(c) + 16) begin
        if (n) exp_st[c][31] = 1'b1;
        else if (w && a == base(c) + 8)  exp_st[c] = exp_st[c] | (d & SLOTS);
        else if (w && a == base(c) + 16) exp_st[c] = exp_st[c] & ~d;
      end
    end
  endfunction

  // called at a negedge, returns at the next negedge
  task automatic bus_wr(int a, logic [31:0] d, logic n = 0);
    sel = 1; en = 1; wr = 1; ns = n; addr = AW'(a); wdata = d;
    model(a, 1'b1, n, d);
    @(negedge clk);
    sel = 0; en = 0; wr = 0; ns = 0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d, input logic n = 0);
    sel = 1; en = 1; wr = 0; ns = n; addr = AW'(a);
    #1 d = rdata;
    model(a, 1'b0, n, '0);
    @(negedge clk);
    sel = 0; en = 0; ns = 0;
  endtask

  task automatic check_state(string tag);
    logic [31:0] v;
    for (int c = 0; c < 2; c++) begin
      bus_rd(base(c), v);
      check(tag, v, exp_st[c]);
    end
    check({tag, " R6 req_irq"}, 32'(req_irq), 32'(|exp_st[1][30:0]));
    check({tag, " R6 rsp_irq"}, 32'(rsp_irq), 32'(|exp_st[0][30:0]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    exp_st[0] = '0; exp_st[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    check("R4 req_irq", 32'(req_irq), 0);
    check("R4 rsp_irq", 32'(rsp_irq), 0);
    check_state("R4 reset status");

    // R1 R2 R3 R6 R10: walk each slot on each channel
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 31; s++) begin
        bus_wr(base(c) + 8, 32'h1 << s);
        check_state("R1 R2 R10 set one slot");
        bus_wr(base(c) + 16, 32'h1 << s);
        check_state("R3 R10 clear one slot");
      end
    end

    // R2 OR semantics with patterns, R3 partial clears
    bus_wr(base(1) + 8, 32'h0000_00F0);
    bus_wr(base(1) + 8, 32'h0F00_000F);
    bus_wr(base(1) + 8, 32'h0);
    check_state("R2 OR patterns");
    bus_wr(base(1) + 16, 32'h0000_0030);
    check_state("R3 partial clear");
    bus_wr(base(0) + 8, 32'h5555_5555);
    bus_wr(base(0) + 16, 32'h0000_FFFF);
    check_state("R3 R10 pattern clear");

    // R5 status read-only, bit 31 of set ignored
    bus_wr(base(0), 32'hFFFF_FFFF);
    bus_wr(base(1), 32'h0);
    check_state("R5 status write ignored");
    bus_wr(base(1) + 16, 32'hFFFF_FFFF);
    bus_wr(base(0) + 16, 32'hFFFF_FFFF);
    bus_wr(base(1) + 8, 32'h8000_0000);
    check_state("R5 R6 set bit31 ignored");

    // R9 set/clear read zero
    for (int c = 0; c < 2; c++) begin
      bus_wr(base(c) + 8, 32'h1234_5678);
      bus_rd(base(c) + 8, v);  check("R9 set reads zero", v, 0);
      bus_rd(base(c) + 16, v); check("R9 clear reads zero", v, 0);
    end

    // R9 sweep every other word address: write all-ones, read back zero
    for (int a = 0; a < (1 << AW); a += 4) begin
      if (a == base(0) || a == base(0)+8 || a == base(0)+16 ||
          a == base(1) || a == base(1)+8 || a == base(1)+16) continue;
      bus_wr(a, 32'hFFFF_FFFF);
      bus_rd(a, v);
      check("R9 undefined address", v, 0);
    end
    check_state("R9 R10 after undefined writes");

    // R7 non-secure accesses: slots untouched, flag set, read zero
    bus_wr(base(1) + 16, 32'hFFFF_FFFF, 1'b1);
    check_state("R7 ns clear write");
    bus_rd(base(0), v, 1'b1);
    check("R7 ns read zero", v, 0);
    check_state("R7 ns read flags response");
    bus_wr(base(0) + 8, 32'h0000_0001, 1'b1);
    bus_wr(base(0), 32'h0, 1'b1);
    check_state("R7 ns set and status write");

    // R8 sticky flag: secure traffic without bit31 keeps it
    bus_wr(base(1) + 16, 32'h7FFF_FFFF);
    bus_wr(base(1) + 8, 32'h0000_0100);
    check_state("R8 flag survives");
    bus_wr(base(1) + 16, 32'h8000_0000);
    check_state("R8 R6 flag cleared");
    bus_wr(base(0) + 16, 32'hFFFF_FFFF);
    bus_wr(base(1) + 16, 32'hFFFF_FFFF);
    check_state("R3 all clear");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule